// File: doc/BRIEF.md
# Per-Source Cell Reassembly Queue

This block sits at an output port of a packet switch whose fabric interleaves fixed-length cells from many inputs. Each arriving cell names the input it came from and says whether it closes its packet. Cells are written once into a shared cell store. One linked list per source gathers the cells of that source's packet in progress. When the closing cell lands, the whole list is hooked onto the tail of the transmit queue in the same clock edge. This is a pointer splice, so no payload is copied. The transmit side then hands out cells one by one, packet after packet, and gives each cell's slot back to the pool of free slots as it leaves.

The free pool is itself a linked list threaded through the same next-pointer store. Slots are taken from its head and returned at its tail. A whole abandoned list can be returned in one step. An abandoned list comes from one of two errors. The first is a cell that finds no free slot: the cell is dropped and its source's packet is written off. The second is a packet that grows past the length limit: it is discarded and a one-cycle error pulse is raised. After either error, the source silently swallows cells until the closing cell of the broken packet goes by.

Each source runs a small state machine with three states. SRC_IDLE means the source holds no cells. SRC_COLLECT means it holds part of a packet. SRC_DISCARD means it is skipping the rest of a broken packet. The transitions are:
- SRC_IDLE to SRC_COLLECT when a stored non-closing cell arrives.
- SRC_COLLECT to SRC_COLLECT as the packet grows.
- SRC_IDLE or SRC_COLLECT back to SRC_IDLE on a stored closing cell, which triggers the splice.
- SRC_IDLE or SRC_COLLECT to SRC_DISCARD on an overlength or no-space event with a non-closing cell. The same event with a closing cell returns to SRC_IDLE.
- SRC_DISCARD to SRC_IDLE on the closing cell.

Top module: `cell_reasm_queue`

## Requirements
- R1: After reset, out_valid and len_err are 0 and all DEPTH cell slots are free.
- R2: The cells of a packet are held back until its closing cell arrives (in_last=1). With nothing else queued, out_valid stays 0 until the clock edge that takes the closing cell.
- R3: A completed packet is sent in the order its cells arrived, with every payload intact. out_eop is 1 on its final cell and 0 on all the others. The packet is offered on out_valid from the cycle after the edge that takes its closing cell.
- R4: Packets from different sources may interleave cell by cell on the input. Each is still sent whole and unmixed, and packets leave in the order in which their closing cells arrived.
- R5: Every cell accepted by out_ready=1 while out_valid=1 returns its slot to the free pool. Arrival and transmission in the same cycle lose no slot: free, queued and partially assembled cells always add up to DEPTH.
- R6: A cell that arrives when no slot is free is dropped, and its source's packet is discarded along with all its later cells through the closing one. Once that closing cell has passed, the source accepts a new packet normally.
- R7: A cell that would make a source's packet longer than MAX_PKT cells is not stored. len_err is 1 in exactly that cell's cycle, and the packet's stored cells are discarded along with its later cells through the closing one.
- R8: A packet of exactly MAX_PKT cells (default 32) is accepted and sent whole, and len_err stays 0.
- R9: While out_valid=1 and out_ready=0, out_valid, out_data and out_eop hold steady.
- R10: Slots freed by transmission or by a discard can be used again. After a full drain, DEPTH cells can once more be taken in and sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A cell is present on the arrival port this cycle |
| in_src | input | $clog2(NUM_SRC) | Input port number the cell came from |
| in_last | input | 1 | 1 marks the closing cell of its packet |
| in_data | input | CELL_W | Cell payload |
| out_ready | input | 1 | Downstream takes the offered cell at the next edge |
| out_valid | output | 1 | A cell is offered on the transmit port |
| out_data | output | CELL_W | Payload of the offered cell |
| out_eop | output | 1 | Offered cell is the final cell of its packet |
| len_err | output | 1 | Pulse: arriving cell made its packet exceed MAX_PKT |

## Verification
The bench interleaves four sources so that packets close in an order different from the order in which they opened. A design that spliced lists in opening order, or that linked one source's cell into another's list, would emit mixed or reordered packets. It fills the whole store with two maximum-length packets and then sends one more cell. A design that wrote past a full pool, or that failed to discard the remainder of the broken packet, would emit extra or garbled cells. It drives a packet one cell past the length limit and checks that the error pulse lands on exactly that cell and on no other. It also keeps the transmit side draining while cells arrive, and then refills the store after draining it. These two steps expose a free pool that loses a slot when a take and a give-back coincide: such a design would fail to accept or emit a later full-size packet.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    // Per-source assembly state.
    typedef enum logic [1:0] {
        SRC_IDLE    = 2'd0,
        SRC_COLLECT = 2'd1,
        SRC_DISCARD = 2'd2
    } src_state_e;

endpackage

// File: rtl/rsq_src_ctx.sv
// One source's assembly context: state machine plus head, tail and count of
// its partial packet. Decisions are combinational on the arriving cell.
module rsq_src_ctx
    import rsq_pkg::*;
#(
    parameter int AW      = 6,
    parameter int MAX_PKT = 32,
    localparam int LW     = $clog2(MAX_PKT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          last_i,
    input  logic          free_ok_i,
    input  logic [AW-1:0] alloc_i,
    output logic [AW-1:0] head_o,
    output logic [AW-1:0] tail_o,
    output logic [LW-1:0] cnt_o,
    output logic          store_o,
    output logic          release_o,
    output logic          splice_o,
    output logic          oversize_o
);

    src_state_e    state_q, state_d;
    logic [AW-1:0] head_q, tail_q;
    logic [LW-1:0] cnt_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    // Next state and action outputs.
    always_comb begin
        state_d    = state_q;
        store_o    = 1'b0;
        release_o  = 1'b0;
        splice_o   = 1'b0;
        oversize_o = 1'b0;
        if (sel_i) begin
            unique case (state_q)
                SRC_DISCARD: begin
                    if (last_i) state_d = SRC_IDLE;
                end
                SRC_IDLE, SRC_COLLECT: begin
                    if (cnt_q == LW'(MAX_PKT)) begin
                        oversize_o = 1'b1;
                        release_o  = 1'b1;
                        state_d    = last_i ? SRC_IDLE : SRC_DISCARD;
                    end else if (!free_ok_i) begin
                        release_o  = (cnt_q != '0);
                        state_d    = last_i ? SRC_IDLE : SRC_DISCARD;
                    end else begin
                        store_o = 1'b1;
                        if (last_i) begin
                            splice_o = 1'b1;
                            state_d  = SRC_IDLE;
                        end else begin
                            state_d  = SRC_COLLECT;
                        end
                    end
                end
                default: state_d = SRC_IDLE;
            endcase
        end
    end

    // List pointers and length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else if (store_o) begin
            if (cnt_q == '0) head_q <= alloc_i;
            tail_q <= alloc_i;
            cnt_q  <= last_i ? '0 : cnt_q + LW'(1);
        end else if (release_o) begin
            cnt_q  <= '0;
        end
    end

    assign head_o = head_q;
    assign tail_o = tail_q;
    assign cnt_o  = cnt_q;

    assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LW'(MAX_PKT));
    assert_idle_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_IDLE) |-> (cnt_q == '0));
    assert_discard_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_DISCARD) |-> (cnt_q == '0));

endmodule

// File: rtl/rsq_free_list.sv
// Free-slot pool kept as a linked list through the shared next-pointer store.
// Per cycle: one take from the head, one whole segment appended, one slot appended.
module rsq_free_list #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_i,
    input  logic [AW-1:0] head_next_i,
    input  logic          seg_en_i,
    input  logic [AW-1:0] seg_head_i,
    input  logic [AW-1:0] seg_tail_i,
    input  logic [CW-1:0] seg_cnt_i,
    input  logic          ret_en_i,
    input  logic [AW-1:0] ret_addr_i,
    output logic [AW-1:0] head_o,
    output logic          avail_o,
    output logic [CW-1:0] cnt_o,
    output logic          lk0_en_o,
    output logic [AW-1:0] lk0_addr_o,
    output logic [AW-1:0] lk0_val_o,
    output logic          lk1_en_o,
    output logic [AW-1:0] lk1_addr_o,
    output logic [AW-1:0] lk1_val_o
);

    logic [AW-1:0] head_q, tail_q, h, t;
    logic [CW-1:0] cnt_q, c;

    always_comb begin
        h = head_q;
        t = tail_q;
        c = cnt_q;
        lk0_en_o = 1'b0; lk0_addr_o = '0; lk0_val_o = '0;
        lk1_en_o = 1'b0; lk1_addr_o = '0; lk1_val_o = '0;
        if (pop_i) begin
            h = head_next_i;
            c = c - CW'(1);
        end
        if (seg_en_i) begin
            if (c == '0) begin
                h = seg_head_i;
            end else begin
                lk0_en_o = 1'b1; lk0_addr_o = t; lk0_val_o = seg_head_i;
            end
            t = seg_tail_i;
            c = c + seg_cnt_i;
        end
        if (ret_en_i) begin
            if (c == '0) begin
                h = ret_addr_i;
            end else begin
                lk1_en_o = 1'b1; lk1_addr_o = t; lk1_val_o = ret_addr_i;
            end
            t = ret_addr_i;
            c = c + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= AW'(DEPTH - 1);
            cnt_q  <= CW'(DEPTH);
        end else begin
            head_q <= h;
            tail_q <= t;
            cnt_q  <= c;
        end
    end

    assign head_o  = head_q;
    assign cnt_o   = cnt_q;
    assign avail_o = (cnt_q != '0);

    assert_free_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    assert_no_take_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (cnt_q != '0));

endmodule

// File: rtl/rsq_out_queue.sv
// Transmit queue: linked list of completed packets. One cell leaves from the
// head and one whole packet can be spliced at the tail in the same cycle.
module rsq_out_queue #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_i,
    input  logic [AW-1:0] head_next_i,
    input  logic          seg_en_i,
    input  logic [AW-1:0] seg_head_i,
    input  logic [AW-1:0] seg_tail_i,
    input  logic [CW-1:0] seg_cnt_i,
    output logic [AW-1:0] head_o,
    output logic [CW-1:0] cnt_o,
    output logic          lk_en_o,
    output logic [AW-1:0] lk_addr_o,
    output logic [AW-1:0] lk_val_o
);

    logic [AW-1:0] head_q, tail_q, h, t;
    logic [CW-1:0] cnt_q, c;

    always_comb begin
        h = head_q;
        t = tail_q;
        c = cnt_q;
        lk_en_o = 1'b0; lk_addr_o = '0; lk_val_o = '0;
        if (pop_i) begin
            h = head_next_i;
            c = c - CW'(1);
        end
        if (seg_en_i) begin
            if (c == '0) begin
                h = seg_head_i;
            end else begin
                lk_en_o = 1'b1; lk_addr_o = t; lk_val_o = seg_head_i;
            end
            t = seg_tail_i;
            c = c + seg_cnt_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            head_q <= h;
            tail_q <= t;
            cnt_q  <= c;
        end
    end

    assign head_o = head_q;
    assign cnt_o  = cnt_q;

    assert_out_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (cnt_q != '0));

endmodule

// File: rtl/cell_reasm_queue.sv
// Output-port reassembly: shared cell store, next-pointer store, per-source
// contexts, free pool and transmit queue.
module cell_reasm_queue
    import rsq_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int CELL_W  = 16,
    parameter int DEPTH   = 64,
    parameter int MAX_PKT = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [$clog2(NUM_SRC)-1:0] in_src,
    input  logic                       in_last,
    input  logic [CELL_W-1:0]          in_data,
    input  logic                       out_ready,
    output logic                       out_valid,
    output logic [CELL_W-1:0]          out_data,
    output logic                       out_eop,
    output logic                       len_err
);

    localparam int SRC_W = $clog2(NUM_SRC);
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int LW    = $clog2(MAX_PKT + 1);

    logic [CELL_W-1:0] cell_mem [DEPTH];
    logic              eop_mem  [DEPTH];
    logic [AW-1:0]     nxt_mem  [DEPTH];

    logic [AW-1:0] s_head [NUM_SRC];
    logic [AW-1:0] s_tail [NUM_SRC];
    logic [LW-1:0] s_cnt  [NUM_SRC];
    logic          s_store [NUM_SRC];
    logic          s_rel   [NUM_SRC];
    logic          s_splice[NUM_SRC];
    logic          s_over  [NUM_SRC];

    logic [AW-1:0] fl_head;
    logic          fl_avail;
    logic [CW-1:0] fl_cnt;
    logic          fl_lk0_en, fl_lk1_en;
    logic [AW-1:0] fl_lk0_addr, fl_lk0_val, fl_lk1_addr, fl_lk1_val;

    logic [AW-1:0] oq_head;
    logic [CW-1:0] oq_cnt;
    logic          oq_lk_en;
    logic [AW-1:0] oq_lk_addr, oq_lk_val;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            rsq_src_ctx #(.AW(AW), .MAX_PKT(MAX_PKT)) u_ctx (
                .clk        (clk),
                .rst_n      (rst_n),
                .sel_i      (in_valid && (in_src == SRC_W'(g))),
                .last_i     (in_last),
                .free_ok_i  (fl_avail),
                .alloc_i    (fl_head),
                .head_o     (s_head[g]),
                .tail_o     (s_tail[g]),
                .cnt_o      (s_cnt[g]),
                .store_o    (s_store[g]),
                .release_o  (s_rel[g]),
                .splice_o   (s_splice[g]),
                .oversize_o (s_over[g])
            );
        end
    endgenerate

    // Actions of the addressed source (only it can act this cycle).
    logic          a_store, a_rel, a_splice;
    logic [LW-1:0] a_cnt;
    logic [AW-1:0] sp_head;
    logic          tx_fire;

    assign a_store  = s_store[in_src];
    assign a_rel    = s_rel[in_src];
    assign a_splice = s_splice[in_src];
    assign a_cnt    = s_cnt[in_src];
    assign sp_head  = (a_cnt == '0) ? fl_head : s_head[in_src];
    assign len_err  = s_over[in_src];

    assign out_valid = (oq_cnt != '0);
    assign out_data  = cell_mem[oq_head];
    assign out_eop   = eop_mem[oq_head];
    assign tx_fire   = out_valid && out_ready;

    rsq_free_list #(.DEPTH(DEPTH)) u_free (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop_i       (a_store),
        .head_next_i (nxt_mem[fl_head]),
        .seg_en_i    (a_rel),
        .seg_head_i  (s_head[in_src]),
        .seg_tail_i  (s_tail[in_src]),
        .seg_cnt_i   (CW'(a_cnt)),
        .ret_en_i    (tx_fire),
        .ret_addr_i  (oq_head),
        .head_o      (fl_head),
        .avail_o     (fl_avail),
        .cnt_o       (fl_cnt),
        .lk0_en_o    (fl_lk0_en),
        .lk0_addr_o  (fl_lk0_addr),
        .lk0_val_o   (fl_lk0_val),
        .lk1_en_o    (fl_lk1_en),
        .lk1_addr_o  (fl_lk1_addr),
        .lk1_val_o   (fl_lk1_val)
    );

    rsq_out_queue #(.DEPTH(DEPTH)) u_outq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop_i       (tx_fire),
        .head_next_i (nxt_mem[oq_head]),
        .seg_en_i    (a_splice),
        .seg_head_i  (sp_head),
        .seg_tail_i  (fl_head),
        .seg_cnt_i   (CW'(a_cnt) + CW'(1)),
        .head_o      (oq_head),
        .cnt_o       (oq_cnt),
        .lk_en_o     (oq_lk_en),
        .lk_addr_o   (oq_lk_addr),
        .lk_val_o    (oq_lk_val)
    );

    // Payload and end-of-packet mark are written once, at arrival.
    always_ff @(posedge clk) begin
        if (a_store) begin
            cell_mem[fl_head] <= in_data;
            eop_mem[fl_head]  <= in_last;
        end
    end

    // Next-pointer store: every writer targets a different list's tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) nxt_mem[i] <= AW'((i + 1) % DEPTH);
        end else begin
            if (a_store && (a_cnt != '0)) nxt_mem[s_tail[in_src]] <= fl_head;
            if (fl_lk0_en) nxt_mem[fl_lk0_addr] <= fl_lk0_val;
            if (fl_lk1_en) nxt_mem[fl_lk1_addr] <= fl_lk1_val;
            if (oq_lk_en)  nxt_mem[oq_lk_addr]  <= oq_lk_val;
        end
    end

    int held_cells;
    always_comb begin
        held_cells = 0;
        for (int i = 0; i < NUM_SRC; i++) held_cells = held_cells + int'(s_cnt[i]);
    end

    assert_cells_conserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fl_cnt) + int'(oq_cnt) + held_cells) == DEPTH);
    assert_hold_offer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eop)));
    assert_err_only_on_cell_R7: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (in_valid && !a_store));

endmodule

// File: tb/cell_reasm_queue_test.sv
module cell_reasm_queue_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_src = '0;
    logic        in_last = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_ready = 1'b0;
    logic        out_valid, out_eop, len_err;
    logic [15:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R3";

    logic [16:0] exp_q[$];
    logic [16:0] pend_d [4][40];
    int          pend_n [4];

    always #5 clk = ~clk;

    cell_reasm_queue uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
        .in_last(in_last), .in_data(in_data), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_eop(out_eop),
        .len_err(len_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] mk(input int src, input int pkt, input int seq);
        return {4'(src), 4'(pkt), 8'(seq)};
    endfunction

    // Transmit monitor: compares every accepted cell with the model.
    always begin
        @(negedge clk);
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_req, "unexpected cell", int'({out_eop, out_data}), 0);
            end else begin
                chk({out_eop, out_data} == exp_q[0], cur_req, "cell {eop,data}",
                    int'({out_eop, out_data}), int'(exp_q[0]));
                void'(exp_q.pop_front());
            end
        end
    end

    // Drive one cell for one cycle; report len_err seen in its cycle.
    task automatic send(input int src, input bit last, input logic [15:0] d,
                        input bit keep, output bit err);
        in_valid = 1'b1; in_src = 2'(src); in_last = last; in_data = d;
        #1 err = len_err;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        if (keep) begin
            pend_d[src][pend_n[src]] = {last, d};
            pend_n[src]++;
            if (last) begin
                for (int k = 0; k < pend_n[src]; k++) exp_q.push_back(pend_d[src][k]);
                pend_n[src] = 0;
            end
        end else if (last) begin
            pend_n[src] = 0;
        end
    endtask

    task automatic send_pkt(input int src, input int pkt, input int len);
        bit e;
        for (int i = 0; i < len; i++) send(src, i == len - 1, mk(src, pkt, i), 1'b1, e);
    endtask

    task automatic drain(input string req);
        int guard = 0;
        cur_req = req;
        out_ready = 1'b1;
        while (exp_q.size() != 0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        out_ready = 1'b0;
        #2;
        chk(exp_q.size() == 0, req, "cells still expected", exp_q.size(), 0);
        chk(out_valid == 1'b0, req, "out_valid after drain", int'(out_valid), 0);
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1", "out_valid at reset", int'(out_valid), 0);
        chk(len_err == 1'b0, "R1", "len_err at reset", int'(len_err), 0);
    endtask

    task automatic t_hold_until_last();
        bit e;
        send(1, 1'b0, mk(1, 1, 0), 1'b1, e);
        chk(out_valid == 1'b0, "R2", "out_valid after first cell", int'(out_valid), 0);
        send(1, 1'b0, mk(1, 1, 1), 1'b1, e);
        chk(out_valid == 1'b0, "R2", "out_valid after second cell", int'(out_valid), 0);
        send(1, 1'b1, mk(1, 1, 2), 1'b1, e);
        chk(out_valid == 1'b1, "R3", "out_valid after closing cell", int'(out_valid), 1);
        chk(out_data == mk(1, 1, 0), "R3", "first offered cell", int'(out_data), int'(mk(1, 1, 0)));
        chk(out_eop == 1'b0, "R3", "eop on first cell", int'(out_eop), 0);
        drain("R3");
    endtask

    task automatic t_interleave();
        bit e;
        send(0, 1'b0, mk(0, 2, 0), 1'b1, e);
        send(1, 1'b0, mk(1, 2, 0), 1'b1, e);
        send(2, 1'b1, mk(2, 2, 0), 1'b1, e);
        send(3, 1'b0, mk(3, 2, 0), 1'b1, e);
        send(0, 1'b1, mk(0, 2, 1), 1'b1, e);
        send(3, 1'b0, mk(3, 2, 1), 1'b1, e);
        send(1, 1'b0, mk(1, 2, 1), 1'b1, e);
        send(3, 1'b1, mk(3, 2, 2), 1'b1, e);
        send(1, 1'b1, mk(1, 2, 2), 1'b1, e);
        drain("R4");
    endtask

    task automatic t_backpressure();
        logic [15:0] d0;
        send_pkt(2, 3, 2);
        d0 = out_data;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid && out_data == d0 && out_eop == 1'b0, "R9", "held offer",
                int'(out_data), int'(d0));
        end
        drain("R9");
    endtask

    task automatic t_concurrent();
        bit e;
        cur_req = "R5";
        out_ready = 1'b1;
        for (int p = 0; p < 6; p++) begin
            for (int i = 0; i < 3; i++) begin
                send(0, i == 2, mk(0, p, i), 1'b1, e);
                send(3, i == 2, mk(3, p, i), 1'b1, e);
            end
        end
        drain("R5");
    endtask

    task automatic t_max_len();
        bit e, any = 1'b0;
        for (int i = 0; i < 32; i++) begin
            send(0, i == 31, mk(0, 4, i), 1'b1, e);
            any |= e;
        end
        chk(any == 1'b0, "R8", "len_err on 32-cell packet", int'(any), 0);
        drain("R8");
    endtask

    task automatic t_oversize();
        bit e;
        for (int i = 0; i < 32; i++) send(3, 1'b0, mk(3, 5, i), 1'b0, e);
        chk(e == 1'b0, "R7", "len_err on 32nd cell", int'(e), 0);
        send(3, 1'b0, mk(3, 5, 32), 1'b0, e);
        chk(e == 1'b1, "R7", "len_err on 33rd cell", int'(e), 1);
        send(3, 1'b0, mk(3, 5, 33), 1'b0, e);
        chk(e == 1'b0, "R7", "len_err while skipping", int'(e), 0);
        send(3, 1'b1, mk(3, 5, 34), 1'b0, e);
        chk(e == 1'b0, "R7", "len_err on closing cell", int'(e), 0);
        chk(out_valid == 1'b0, "R7", "discarded packet emitted", int'(out_valid), 0);
        send_pkt(3, 6, 2);
        drain("R7");
    endtask

    task automatic t_full_store();
        bit e;
        send_pkt(0, 7, 32);
        send_pkt(1, 7, 32);
        send(2, 1'b0, mk(2, 7, 0), 1'b0, e);
        drain("R6");
        send(2, 1'b0, mk(2, 7, 1), 1'b0, e);
        send(2, 1'b1, mk(2, 7, 2), 1'b0, e);
        chk(out_valid == 1'b0, "R6", "tail of broken packet emitted", int'(out_valid), 0);
        send_pkt(2, 8, 2);
        drain("R6");
        send_pkt(0, 9, 32);
        send_pkt(1, 9, 32);
        chk(out_valid == 1'b1, "R10", "refilled store offers cells", int'(out_valid), 1);
        drain("R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++) pend_n[s] = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_hold_until_last();
        t_interleave();
        t_backpressure();
        t_concurrent();
        t_max_len();
        t_oversize();
        t_full_store();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule